// File: doc/BRIEF.md
# Timer Channel Event Counter

This block is one timer channel running as an event counter. Software gives it a reload value through a data register. A one-cycle start strobe enables the channel, and on the next clock the reload value is copied into the count register. From then on the count register decrements once for every valid edge seen on an external input that is asynchronous to the module clock. When a valid edge arrives while the count is zero, the channel reloads from the data register and pulses its interrupt output for one clock cycle.

The external input is sampled by a two-flop synchronizer and then passed to an edge detector. An optional noise filter can be placed in the path. With the filter on, a level reaches the edge detector only after it has held for two more samples, which adds two clocks of latency and rejects short glitches. A 2-bit select chooses whether falling edges, rising edges or both edges count.

Top module: `evt_count_chan`

## Requirements
- R1: After reset the count output is 0x0000, the enable output is 0 and the interrupt output is 0.
- R2: While the channel is disabled, edges on the external input leave the count output unchanged.
- R3: A start strobe sets the enable output on the next clock and a stop strobe clears it. When both strobes are high in the same cycle, the stop strobe wins, whether the channel was enabled or disabled before.
- R4: On the second rising clock edge after a start strobe, the count output equals the data register value.
- R5: While enabled, each valid edge decrements the count by one. Edge select encoding: 2'b00 counts falling edges, 2'b01 counts rising edges, 2'b10 counts both edges, and 2'b11 counts falling edges.
- R6: With the filter off, a change of the external input set up before clock edge 1 changes the count on clock edge 3.
- R7: With the filter on, the same change moves the count on clock edge 5. A level that lasts 2 clock cycles or less is rejected, and a level that lasts 3 cycles or more passes.
- R8: A valid edge while the count is 0 reloads the data register value and raises the interrupt output for exactly one cycle.
- R9: A data register write while counting leaves the count unchanged. The new value is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| stop_i | input | 1 | One-cycle stop strobe |
| edge_sel_i | input | 2 | Valid edge select |
| filt_en_i | input | 1 | Noise filter enable |
| ext_in_i | input | 1 | Asynchronous external event input |
| data_we_i | input | 1 | Data register write enable |
| data_wd_i | input | W | Data register write value |
| count_o | output | W | Live count value |
| enabled_o | output | 1 | Channel enable status |
| irq_o | output | 1 | One-cycle event interrupt pulse |

## Verification
The embedded properties assume that the filter enable and the edge select change only while the channel is stopped and the input level is settled. They also assume that the start and stop strobes last one cycle. The stimulus respects this. It changes the configuration only after a stop and a settling delay, and it spaces input transitions eight clocks apart, except in the deliberate glitch and latency tests. In those tests the pulse widths are chosen so that every sampled level is well defined.

// File: rtl/evt_count_chan.sv
module evt_count_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic [1:0]   edge_sel_i,
  input  logic         filt_en_i,
  input  logic         ext_in_i,
  input  logic         data_we_i,
  input  logic [W-1:0] data_wd_i,
  output logic [W-1:0] count_o,
  output logic         enabled_o,
  output logic         irq_o
);

  logic         s1_q, s2_q, h1_q, h2_q, lvl_q;
  logic         en_q, pend_q, irq_q;
  logic [W-1:0] cnt_q, data_q;

  wire stable = (s2_q == h1_q) && (h1_q == h2_q);
  wire lvl    = filt_en_i ? (stable ? s2_q : lvl_q) : s2_q;
  wire rise   = lvl & ~lvl_q;
  wire fall   = ~lvl & lvl_q;
  wire vedge  = (edge_sel_i == 2'b01) ? rise :
                (edge_sel_i == 2'b10) ? (rise | fall) : fall;
  wire go     = start_i & ~stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      h1_q   <= 1'b0;
      h2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      s1_q   <= ext_in_i;
      s2_q   <= s1_q;
      h1_q   <= s2_q;
      h2_q   <= h1_q;
      lvl_q  <= lvl;
      pend_q <= go;
      irq_q  <= 1'b0;
      if (data_we_i) data_q <= data_wd_i;
      if (stop_i)       en_q <= 1'b0;
      else if (start_i) en_q <= 1'b1;
      if (pend_q && !stop_i) begin
        cnt_q <= data_q;
      end else if (en_q && !pend_q && vedge) begin
        if (cnt_q == '0) begin
          cnt_q <= data_q;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign count_o   = cnt_q;
  assign enabled_o = en_q;
  assign irq_o     = irq_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start_i) |=> $stable(cnt_q));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> en_q);

  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !en_q);

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !stop_i) |=> (cnt_q == $past(data_q)));

  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !pend_q && vedge && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  p_filt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en_i && s2_q != h1_q) |-> (lvl == lvl_q));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !pend_q && vedge && cnt_q == '0) |=> (irq_q && cnt_q == $past(data_q)));

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(cnt_q) == '0));

endmodule

// File: tb/evt_count_chan_tb.sv
module evt_count_chan_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, stop_i = 1'b0, filt_en_i = 1'b0, ext_in_i = 1'b0;
  logic         data_we_i = 1'b0;
  logic [1:0]   edge_sel_i = 2'b00;
  logic [W-1:0] data_wd_i = '0;
  logic [W-1:0] count_o;
  logic         enabled_o, irq_o;

  int tests = 0, fails = 0, irq_seen = 0;

  always #4 clk = ~clk;

  evt_count_chan #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .edge_sel_i(edge_sel_i), .filt_en_i(filt_en_i), .ext_in_i(ext_in_i),
    .data_we_i(data_we_i), .data_wd_i(data_wd_i),
    .count_o(count_o), .enabled_o(enabled_o), .irq_o(irq_o));

  always @(posedge clk) begin
    #1;
    if (irq_o) irq_seen++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_data(input int v);
    data_we_i = 1'b1; data_wd_i = W'(v); tick(1);
    data_we_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1; tick(1);
    start_i = 1'b0; tick(1);
  endtask

  task automatic do_stop();
    stop_i = 1'b1; tick(1);
    stop_i = 1'b0;
  endtask

  function automatic bit valid(input int sel, input bit newlvl);
    if (sel == 1) return newlvl;
    if (sel == 2) return 1'b1;
    return !newlvl;
  endfunction

  initial begin
    tick(3);
    chk("R1 count", count_o, 0);
    chk("R1 enable", enabled_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    tick(2);

    // R2: edges while disabled
    set_data(7);
    edge_sel_i = 2'b10;
    for (int k = 0; k < 4; k++) begin ext_in_i = ~ext_in_i; tick(8); end
    chk("R2 count held", count_o, 0);
    chk("R2 enable low", enabled_o, 0);

    // R3: strobes
    start_i = 1'b1; stop_i = 1'b1; tick(1); start_i = 1'b0; stop_i = 1'b0;
    chk("R3 both while off", enabled_o, 0);
    do_start();
    chk("R3 start", enabled_o, 1);
    chk("R4 load", count_o, 7);
    start_i = 1'b1; stop_i = 1'b1; tick(1); start_i = 1'b0; stop_i = 1'b0;
    chk("R3 both while on", enabled_o, 0);
    tick(4);

    // Sweep: R4 R5 R8
    for (int f = 0; f < 2; f++)
      for (int sel = 0; sel < 4; sel++)
        for (int d = 0; d < 4; d++) begin
          int model, irq_exp, irq_base;
          do_stop();
          ext_in_i = 1'b0; tick(10);
          filt_en_i = f[0]; edge_sel_i = sel[1:0];
          tick(2);
          set_data(d);
          do_start();
          chk("R4 sweep load", count_o, d);
          model = d; irq_exp = 0; irq_base = irq_seen;
          for (int k = 0; k < 10; k++) begin
            ext_in_i = ~ext_in_i; tick(8);
            if (valid(sel, ext_in_i)) begin
              if (model == 0) begin model = d; irq_exp++; end
              else model--;
            end
            chk("R5 sweep count", count_o, model);
          end
          chk("R8 irq pulses", irq_seen - irq_base, irq_exp);
        end

    // R6 / R7 latency
    do_stop(); ext_in_i = 1'b0; filt_en_i = 1'b0; edge_sel_i = 2'b10; tick(10);
    set_data(5); do_start();
    ext_in_i = 1'b1; tick(2);
    chk("R6 before edge 3", count_o, 5);
    tick(1);
    chk("R6 at edge 3", count_o, 4);
    do_stop(); filt_en_i = 1'b1; tick(10); do_start();
    ext_in_i = 1'b0; tick(4);
    chk("R7 before edge 5", count_o, 5);
    tick(1);
    chk("R7 at edge 5", count_o, 4);
    tick(6);

    // R7 glitch rejection and pass
    ext_in_i = 1'b1; tick(2); ext_in_i = 1'b0; tick(10);
    chk("R7 2-cycle rejected", count_o, 4);
    ext_in_i = 1'b1; tick(3); ext_in_i = 1'b0; tick(10);
    chk("R7 3-cycle passes", count_o, 2);
    do_stop(); filt_en_i = 1'b0; tick(10); do_start();
    ext_in_i = 1'b1; tick(2); ext_in_i = 1'b0; tick(10);
    chk("R6 unfiltered 2-cycle", count_o, 3);

    // R9 data write while counting
    set_data(9);
    chk("R9 write no effect", count_o, 3);
    for (int k = 0; k < 3; k++) begin ext_in_i = ~ext_in_i; tick(8); end
    chk("R9 reached zero", count_o, 0);
    ext_in_i = ~ext_in_i; tick(8);
    chk("R9 new reload", count_o, 9);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule